// File: doc/BRIEF.md
# MDIO Clause 45 Management Master

This block is a station-management master for a two-wire management bus that uses indirect (Clause 45 style) framing. A host places one request on the command side: an operation code, a 5-bit port address, a 5-bit device address and a 16-bit payload. The block then produces a complete 64 bit-time frame on the bus. The management clock is derived from the system clock by a fixed divider, and the data line is driven through a separate output-enable.

Three frame kinds are supported: address frames, which set the register pointer in the target; write-data frames; and read frames. For a read, the master releases the data line during the turnaround and the data field, shifts in the 16 bits the target returns, and presents them when the frame ends. The post-read-increment code is refused with a one-cycle error pulse. While a frame is in progress, further requests are ignored.

Top module: `mdio_c45_master`

## Requirements
- R1: A frame lasts 64 bit-times. Bit-time i carries frame bit i. Bits 0–31 are ones. Bits 32–33 are the start pattern 00. Bits 34–35 are the operation code, high bit first. Bits 36–40 are the port address and bits 41–45 the device address, each MSB first. Bits 46–47 are the turnaround. Bits 48–63 are the payload, bit 15 first.
- R2: Operation codes are 00 (address), 01 (write) and 11 (read). A request with code 10 made while idle raises `err` for exactly one cycle, beginning the cycle after the request, and starts no frame.
- R3: On address and write frames the master drives every bit-time. The turnaround is 1 and then 0.
- R4: On read frames `mdio_oe` is low for bit-times 46–63. The master samples `mdio_i` at each MDC rising edge of bit-times 48–63, MSB first. The 16 sampled bits appear on `rdata` when `done` pulses.
- R5: While a frame runs, MDC has a period of 2×MDC_DIV system clocks. Its first rising edge comes MDC_DIV cycles after the accepting clock edge. MDC is low when idle.
- R6: While the bus is driven, `mdio_o` and `mdio_oe` change only at MDC falling edges, half a period after the rising edge that sampled the previous bit. At the accepting edge they take the first bit.
- R7: `busy` is high from the accepting edge for 128×MDC_DIV cycles. `done` pulses for one cycle in the cycle `busy` falls.
- R8: A request that arrives while `busy` is high has no effect. It does not change the frame in progress, it does not raise `err`, and it starts no later frame.
- R9: `rdata` keeps its value through address and write frames and changes only when a read frame completes.
- R10: When idle, `mdio_oe` and `mdc` are low.
- R11: After reset, `busy`, `done`, `err`, `mdc` and `mdio_oe` are low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 2 | Operation code |
| req_port | input | 5 | Port address |
| req_dev | input | 5 | Device address |
| req_wdata | input | 16 | Register address or write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | One-cycle illegal-code pulse |
| rdata | output | 16 | Data from the last read frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Every result is given a due cycle, counted from the clock edge that accepts the request. Rising edge j of MDC is due at cycle MDC_DIV·(2j+1) and falling edge j at cycle 2·MDC_DIV·(j+1). `done` and the drop of `busy` are due at cycle 128·MDC_DIV, and `err` is due one cycle after the refused request. The bench samples one time unit after each system clock edge and compares every edge against its computed cycle. It captures the bus bit and the enable at each rising edge, and any change of the line outside a falling edge counts as a violation. The target side of a read is modelled by changing `mdio_i` only after MDC falls.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

  localparam int unsigned FRAME_LEN = 64;
  localparam int unsigned PRE_LEN   = 32;
  localparam int unsigned TA_POS    = 46;
  localparam int unsigned DATA_POS  = 48;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);

  typedef enum logic [1:0] {
    OPC_ADDR  = 2'b00,
    OPC_WRITE = 2'b01,
    OPC_RINC  = 2'b10,
    OPC_READ  = 2'b11
  } opc_e;

  // Whole frame, bit-time 0 at the MSB.
  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic [1:0]  op,
    input logic [4:0]  prt,
    input logic [4:0]  dev,
    input logic [15:0] wd
  );
    logic [1:0]  ta;
    logic [15:0] pl;
    if (op == OPC_READ) begin
      ta = 2'b11;
      pl = 16'hFFFF;
    end else begin
      ta = 2'b10;
      pl = wd;
    end
    return {{PRE_LEN{1'b1}}, 2'b00, op, prt, dev, ta, pl};
  endfunction

endpackage

// File: rtl/mdio_c45_clkgen.sv
module mdio_c45_clkgen #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);

  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             mdc_q, mdc_n;
  logic             wrap;

  assign wrap      = (cnt_q == LAST);
  assign rise_tick = run & wrap & ~mdc_q;
  assign fall_tick = run & wrap &  mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_n = cnt_q;
    mdc_n = mdc_q;
    if (!run) begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end else if (wrap) begin
      cnt_n = '0;
      mdc_n = ~mdc_q;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end

  // R5: every MDC edge while running follows a full half-period count
  p_half_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (mdc_q != $past(mdc_q))) |-> ($past(cnt_q) == LAST));

  // R5: MDC is never high while the divider is stopped
  p_mdc_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc_q);

endmodule

// File: rtl/mdio_c45_req.sv
module mdio_c45_req
  import mdio_c45_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic [4:0]           req_port,
  input  logic [4:0]           req_dev,
  input  logic [15:0]          req_wdata,
  input  logic                 busy,
  output logic                 start,
  output logic [FRAME_LEN-1:0] start_frame,
  output logic                 start_read,
  output logic                 err
);

  logic illegal;
  logic err_q, err_n;

  assign illegal     = (req_op == OPC_RINC);
  assign start       = req_valid & ~busy & ~illegal;
  assign start_read  = (req_op == OPC_READ);
  assign start_frame = build_frame(req_op, req_port, req_dev, req_wdata);
  assign err         = err_q;

  always_comb begin
    err_n = req_valid & ~busy & illegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_n;
  end

  // R2: the refused code never starts a frame
  p_no_rinc_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (req_op != OPC_RINC));

  // R8: nothing starts while a frame is in progress
  p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

// File: rtl/mdio_c45_seq.sv
module mdio_c45_seq
  import mdio_c45_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FRAME_LEN-1:0] start_frame,
  input  logic                 start_read,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic                 mdio_i,
  output logic                 active,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic [15:0]          rdata
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_POS);

  logic                 active_q, active_n;
  logic                 rd_q, rd_n;
  logic [IDX_W-1:0]     idx_q, idx_n;
  logic [FRAME_LEN-1:0] sh_q, sh_n;
  logic [15:0]          rx_q, rx_n;
  logic [15:0]          rdata_q, rdata_n;
  logic                 done_q, done_n;
  logic                 released;

  assign released = rd_q & (idx_q >= IDX_TA);
  assign mdio_oe  = active_q & ~released;
  assign mdio_o   = mdio_oe & sh_q[FRAME_LEN-1];
  assign active   = active_q;
  assign done     = done_q;
  assign rdata    = rdata_q;

  always_comb begin
    active_n = active_q;
    rd_n     = rd_q;
    idx_n    = idx_q;
    sh_n     = sh_q;
    rx_n     = rx_q;
    rdata_n  = rdata_q;
    done_n   = 1'b0;
    if (!active_q) begin
      if (start) begin
        active_n = 1'b1;
        rd_n     = start_read;
        idx_n    = '0;
        sh_n     = start_frame;
      end
    end else begin
      if (rise_tick && rd_q && (idx_q >= IDX_DATA)) begin
        rx_n = {rx_q[14:0], mdio_i};
      end
      if (fall_tick) begin
        if (idx_q == IDX_LAST) begin
          active_n = 1'b0;
          done_n   = 1'b1;
          if (rd_q) rdata_n = rx_q;
        end else begin
          idx_n = idx_q + 1'b1;
          sh_n  = {sh_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_n;
      rd_q     <= rd_n;
      idx_q    <= idx_n;
      sh_q     <= sh_n;
      rx_q     <= rx_n;
      rdata_q  <= rdata_n;
      done_q   <= done_n;
    end
  end

  // R3: a driven frame puts 1 on the line in the first turnaround bit
  p_ta_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !rd_q && idx_q == IDX_TA) |-> (mdio_oe && mdio_o));

  // R4: ticks are only seen while a frame is active
  p_tick_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_tick || fall_tick) |-> active_q);

  // R9: read data only moves on completion of a read
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(rdata_q));

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int unsigned MDC_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [4:0]  req_port,
  input  logic [4:0]  req_dev,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic [1:0]           rs_q;
  logic                 rst_int_n;
  logic                 start;
  logic [FRAME_LEN-1:0] start_frame;
  logic                 start_read;
  logic                 active;
  logic                 rise_tick;
  logic                 fall_tick;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign busy = active;

  mdio_c45_req u_req (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_port    (req_port),
    .req_dev     (req_dev),
    .req_wdata   (req_wdata),
    .busy        (active),
    .start       (start),
    .start_frame (start_frame),
    .start_read  (start_read),
    .err         (err)
  );

  mdio_c45_clkgen #(.DIV(MDC_DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (active),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_c45_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start),
    .start_frame (start_frame),
    .start_read  (start_read),
    .rise_tick   (rise_tick),
    .fall_tick   (fall_tick),
    .mdio_i      (mdio_i),
    .active      (active),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .done        (done),
    .rdata       (rdata)
  );

  // R6: the line holds still while MDC stays high
  p_stable_high_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R10: idle bus is released with MDC low
  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> (!mdc && !mdio_oe));

  // R7: done is a single-cycle pulse that coincides with the end of busy
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);
  p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (!busy && $past(busy)));

  // R2: an error pulse never accompanies a frame start
  p_err_idle_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    err |-> !busy);

endmodule

// File: tb/mdio_c45_master_bench.sv
`timescale 1ns/1ps
module mdio_c45_master_bench;

  localparam int DIV  = 3;
  localparam int FLEN = 128 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [4:0]  req_port = '0;
  logic [4:0]  req_dev = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, err, mdc, mdio_o, mdio_oe;
  logic [15:0] rdata;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  logic [15:0] last_rdata = '0;

  always #2.5 clk = ~clk;

  mdio_c45_master #(.MDC_DIV(DIV)) u_mdio_c45_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_port(req_port), .req_dev(req_dev), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic resp_bit(input int n, input logic [15:0] resp);
    if (n < 47) return 1'b1;
    if (n == 47) return 1'b0;
    if (n < 64) return resp[63 - n];
    return 1'b1;
  endfunction

  task automatic run_frame(input logic [1:0] op, input logic [4:0] prt, input logic [4:0] dev,
                           input logic [15:0] wd, input logic [15:0] resp, input bit inject);
    logic [63:0] exp_bits, exp_oe, got_bits, got_oe;
    logic [15:0] exp_rd;
    int rises, bad_rise, bad_stab, done_cnt, done_k, bad_busy, err_seen;
    logic pm, po, poe;
    exp_bits = {32'hFFFF_FFFF, 2'b00, op, prt, dev, 2'b10, wd};
    exp_oe   = (op == 2'b11) ? ~64'h3FFFF : '1;
    got_bits = '0; got_oe = '0;
    rises = 0; bad_rise = 0; bad_stab = 0; done_cnt = 0; done_k = -1; bad_busy = 0; err_seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_port = prt; req_dev = dev; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
    mdio_i = 1'b1;
    pm = mdc; po = mdio_o; poe = mdio_oe;
    for (int k = 0; k <= FLEN + 8; k++) begin
      if (k > 0) begin
        @(posedge clk); #1;
      end
      if (inject) begin
        // R8: requests during a frame
        if (k == 100) begin
          req_valid = 1'b1; req_op = 2'b01; req_port = ~prt; req_dev = ~dev; req_wdata = ~wd;
        end
        if (k == 150) begin
          req_valid = 1'b1; req_op = 2'b10;
        end
        if (k == 101 || k == 151) req_valid = 1'b0;
      end
      if (busy != (k < FLEN)) bad_busy++;
      if (done) begin done_cnt++; done_k = k; end
      if (err) err_seen++;
      if (mdc && !pm) begin
        if (k != DIV + 2 * DIV * rises) bad_rise++;
        if (rises < 64) begin
          got_bits[63 - rises] = mdio_o;
          got_oe[63 - rises]   = mdio_oe;
        end
        rises++;
      end
      if (!mdc && pm) begin
        if (k != 2 * DIV * rises) bad_rise++;
        mdio_i = resp_bit(rises, resp);
      end else if (k > 0 && (mdio_o != po || mdio_oe != poe)) begin
        bad_stab++;
      end
      pm = mdc; po = mdio_o; poe = mdio_oe;
    end
    // R1: bit content of the driven bit-times
    chk((got_bits & exp_oe) == (exp_bits & exp_oe), "R1 frame bits", got_bits & exp_oe, exp_bits & exp_oe);
    if (op == 2'b11)
      chk(got_oe == exp_oe, "R4 read release pattern", got_oe, exp_oe);
    else
      chk(got_oe == exp_oe && got_bits[17:16] == 2'b10, "R3 driven turnaround", {got_oe[63:2], got_bits[17:16]}, {exp_oe[63:2], 2'b10});
    chk(rises == 64 && bad_rise == 0, "R5 MDC edge timing", 64'(rises * 1000 + bad_rise), 64'(64000));
    chk(bad_stab == 0, "R6 line changes only at falling edges", 64'(bad_stab), 64'd0);
    chk(done_cnt == 1 && done_k == FLEN, "R7 done pulse cycle", 64'(done_k), 64'(FLEN));
    chk(bad_busy == 0, "R7 busy window", 64'(bad_busy), 64'd0);
    exp_rd = (op == 2'b11) ? resp : last_rdata;
    if (op == 2'b11)
      chk(rdata == exp_rd, "R4 read data", 64'(rdata), 64'(exp_rd));
    else
      chk(rdata == exp_rd, "R9 read data held", 64'(rdata), 64'(exp_rd));
    last_rdata = exp_rd;
    if (inject)
      chk(err_seen == 0 && !busy && !mdc && !mdio_oe, "R8 busy request ignored",
          64'({err_seen[7:0], busy, mdc, mdio_oe}), 64'd0);
  endtask

  task automatic err_case();
    int bad;
    bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b10; req_port = 5'h15; req_dev = 5'h0A; req_wdata = 16'h1234;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R2 error pulse on code 10", 64'({err, busy}), 64'b10);
    @(posedge clk); #1;
    chk(err == 1'b0, "R2 error lasts one cycle", 64'(err), 64'd0);
    for (int k = 0; k < 40; k++) begin
      if (mdc || mdio_oe || busy || done) bad++;
      @(posedge clk); #1;
    end
    chk(bad == 0, "R10 bus idle after refused code", 64'(bad), 64'd0);
    chk(rdata == last_rdata, "R9 rdata unchanged by refused code", 64'(rdata), 64'(last_rdata));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] opt;
    repeat (5) @(posedge clk);
    #1;
    // R11: state while reset held
    chk({busy, done, err, mdc, mdio_oe} == 5'b0 && rdata == 16'h0, "R11 reset state",
        {43'd0, busy, done, err, mdc, mdio_oe, rdata}, 64'd0);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk({busy, done, err, mdc, mdio_oe} == 5'b0 && rdata == 16'h0, "R11 state after release",
        {43'd0, busy, done, err, mdc, mdio_oe, rdata}, 64'd0);
    // R10: idle with no request
    chk(!mdc && !mdio_oe, "R10 idle bus", 64'({mdc, mdio_oe}), 64'd0);
    // Sweep every port address with all three legal codes
    for (int i = 0; i < 32; i++) begin
      case (i % 3)
        0: opt = 2'b00;
        1: opt = 2'b01;
        default: opt = 2'b11;
      endcase
      run_frame(opt, 5'(i), 5'(31 - i), 16'(i * 4951) ^ 16'hA5C3,
                16'(i * 7919) ^ 16'h3C5A, (i % 8) == 5);
    end
    // Boundary payloads
    run_frame(2'b01, 5'h00, 5'h00, 16'h0000, 16'h0000, 1'b0);
    run_frame(2'b11, 5'h1F, 5'h1F, 16'h0000, 16'hFFFF, 1'b0);
    run_frame(2'b11, 5'h00, 5'h1F, 16'hFFFF, 16'h0000, 1'b1);
    run_frame(2'b00, 5'h1F, 5'h00, 16'hFFFF, 16'h8001, 1'b0);
    err_case();
    run_frame(2'b11, 5'h0C, 5'h03, 16'h0000, 16'h8001, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule